// File: doc/BRIEF.md
# Synthesizer Configuration Receiver over I2C

This block is a write-only I2C target that sits in front of a fractional-N frequency synthesizer and turns a short serial transfer into its configuration. After a matching address, each byte is sorted by its leading bits. A byte with a clear MSB opens a three-byte divider group that carries the reference ratio select and the 15-bit scaling factor. A byte whose two top bits are both set opens a two-byte control group. The first control byte holds the tuning-output-off, test, pump-off and pump-current bits. The second holds the doubler-off and doubler-high-current bits and six switch-output bits.

Received fields land in shadow registers and reach the outputs only at the STOP that ends the transfer. Each group is applied only if it arrived complete. A one-cycle update strobe marks every STOP that closes a transfer addressed to this block. A sticky flag reports that a complete scaling factor has been applied at least once since reset, so the divider logic downstream can be held idle until then. Two address bits come from a strap input. SCL and SDA pass through a two-flop synchronizer, and START and STOP are recognised as SDA edges while SCL is high.

Top module: `synth_cfg_i2c`

## Requirements
- R1: The address byte must equal 1100_0, then addr_sel_i[1], then addr_sel_i[0], then a 0 write bit (MSB first). Any other address, and any read request, gets no acknowledge, and the bytes that follow it up to the next START change no output.
- R2: Every accepted byte (the address and each following byte) is acknowledged by asserting sda_oe_o while SCL is low before the ninth clock. sda_oe_o is released after the ninth falling edge, so that sda_oe_o stays low during the eight data clocks.
- R3: A byte in selector position with bit 7 equal to 0 starts the divider group. In that first byte, bits 6:5 give ref_sel_o[1:0] and bits 2:0 give scale bits 14:12. The low six bits of the next byte give scale bits 11:6, and the low six bits of the byte after that give scale bits 5:0.
- R4: A byte in selector position with bits 7:6 equal to 11 is control byte one. Its bit 4 sets tune_off_o, bit 3 sets test_o, bit 2 sets pump_off_o and bits 1:0 set pump_cur_o. The next byte is control byte two: bit 7 sets dbl_off_o, bit 6 sets dbl_hi_o and bits 5:0 set sw_o[5:0].
- R5: A byte in selector position with bits 7:6 equal to 10 is acknowledged but otherwise ignored. The byte after it is again taken as a selector.
- R6: No configuration output changes during a transfer. Outputs change only in the cycle after a STOP is detected.
- R7: scale_o and ref_sel_o are updated at STOP only if the last divider group started in that transfer delivered all three bytes. An incomplete group leaves them unchanged, and the control groups are applied independently of it.
- R8: update_o is a single-cycle pulse, given once per STOP that closes a transfer whose address matched, and never otherwise.
- R9: scale_valid_o is 0 after reset. It becomes 1 at the first STOP that applies a complete divider group and stays 1 until reset.
- R10: After reset every configuration output is 0, update_o and scale_valid_o are 0, and sda_oe_o is released (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired line, including own pull-down) |
| addr_sel_i | input | 2 | Strapped low address bits: [1] is the higher of the two |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| scale_o | output | 15 | Main divider scaling factor |
| ref_sel_o | output | 2 | Reference divider ratio select |
| pump_cur_o | output | 2 | Charge pump current code |
| pump_off_o | output | 1 | Charge pump disabled |
| test_o | output | 1 | Divider test monitor enable |
| tune_off_o | output | 1 | Tuning amplifier output off |
| dbl_off_o | output | 1 | Reference doubler off |
| dbl_hi_o | output | 1 | Doubler output current doubled |
| sw_o | output | 6 | Switch output enables |
| update_o | output | 1 | One-cycle strobe when a transfer to this block ends |
| scale_valid_o | output | 1 | A complete scaling factor has been applied since reset |

## Verification
The bench first sends an incomplete divider group, then a full six-byte transfer with distinct bit patterns in every field. Comparing these two tells whole-group commit apart from byte-wise commit, and also shows that each field lands in its own bit position. It then sends transfers to a wrong address and a read request to confirm that neither is acknowledged or applied. A control-only transfer that starts with a 10 selector byte separates the steering by leading bits from plain byte counting. A check that samples the outputs before STOP shows that the update waits for the end of the transfer. A last transfer with different strap bits confirms that the address tracks addr_sel_i.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int SCALE_W = 15;
  localparam int SW_N    = 6;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    logic [1:0]         ref_sel;
  } div_cfg_t;

  typedef struct packed {
    logic       tune_off;
    logic       test_en;
    logic       pump_off;
    logic [1:0] pump_cur;
  } ctl1_cfg_t;

  typedef struct packed {
    logic            dbl_off;
    logic            dbl_hi;
    logic [SW_N-1:0] sw;
  } ctl2_cfg_t;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK, RX_IGNORE} rx_state_t;
  typedef enum logic [1:0] {SEQ_SEL, SEQ_DIV2, SEQ_DIV3, SEQ_CTL2} seq_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] now_q;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign now_q[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= now_q;
  end

  // bit 1 = SCL, bit 0 = SDA
  assign scl_o      = now_q[1];
  assign sda_o      = now_q[0];
  assign scl_rise_o = now_q[1] & ~prev_q[1];
  assign scl_fall_o = ~now_q[1] & prev_q[1];
  assign start_o    = now_q[1] & prev_q[1] & prev_q[0] & ~now_q[0];
  assign stop_o     = now_q[1] & prev_q[1] & ~prev_q[0] & now_q[0];
endmodule

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
  import synth_cfg_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        addr_lo_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sel_o,
  output logic              ack_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              first;
  logic              addr_hit;

  assign addr_hit = (shreg == {ADDR_HI, addr_lo_i, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      first      <= 1'b0;
      sel_o      <= 1'b0;
      ack_o      <= 1'b0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (start_i) begin
        state   <= RX_BITS;
        bit_cnt <= '0;
        first   <= 1'b1;
        sel_o   <= 1'b0;
        ack_o   <= 1'b0;
      end else if (stop_i) begin
        state <= RX_IDLE;
        sel_o <= 1'b0;
        ack_o <= 1'b0;
      end else begin
        case (state)
          RX_BITS: begin
            if (scl_rise_i) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i && bit_cnt == CNT_W'(BYTE_W)) begin
              bit_cnt <= '0;
              if (first) begin
                first <= 1'b0;
                if (addr_hit) begin
                  sel_o <= 1'b1;
                  ack_o <= 1'b1;
                  state <= RX_ACK;
                end else begin
                  state <= RX_IGNORE;
                end
              end else begin
                ack_o      <= 1'b1;
                byte_vld_o <= 1'b1;
                state      <= RX_ACK;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall_i) begin
              ack_o <= 1'b0;
              state <= RX_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign byte_o = shreg;

  // R2
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> !scl_i);

  // R1
  ack_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> sel_o);
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic              stop_i,
  output div_cfg_t          div_q,
  output ctl1_cfg_t         c1_q,
  output ctl2_cfg_t         c2_q,
  output logic              update_o,
  output logic              valid_o
);
  localparam int HI_W  = 3;
  localparam int SEG_W = 6;

  seq_state_t seq;
  div_cfg_t   div_sh;
  ctl1_cfg_t  c1_sh;
  ctl2_cfg_t  c2_sh;
  logic       div_ok, c1_ok, c2_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq      <= SEQ_SEL;
      div_sh   <= '0;
      c1_sh    <= '0;
      c2_sh    <= '0;
      div_ok   <= 1'b0;
      c1_ok    <= 1'b0;
      c2_ok    <= 1'b0;
      div_q    <= '0;
      c1_q     <= '0;
      c2_q     <= '0;
      update_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      update_o <= 1'b0;
      if (stop_i) begin
        if (sel_i) begin
          update_o <= 1'b1;
          if (div_ok) begin
            div_q   <= div_sh;
            valid_o <= 1'b1;
          end
          if (c1_ok) c1_q <= c1_sh;
          if (c2_ok) c2_q <= c2_sh;
        end
        div_ok <= 1'b0;
        c1_ok  <= 1'b0;
        c2_ok  <= 1'b0;
        seq    <= SEQ_SEL;
      end else if (start_i) begin
        seq <= SEQ_SEL;
      end else if (byte_vld_i) begin
        case (seq)
          SEQ_SEL: begin
            if (!byte_i[7]) begin
              div_sh.ref_sel                      <= byte_i[6:5];
              div_sh.scale[SCALE_W-1 -: HI_W]     <= byte_i[HI_W-1:0];
              div_ok                              <= 1'b0;
              seq                                 <= SEQ_DIV2;
            end else if (byte_i[6]) begin
              c1_sh <= '{tune_off: byte_i[4], test_en: byte_i[3],
                         pump_off: byte_i[2], pump_cur: byte_i[1:0]};
              c1_ok <= 1'b1;
              seq   <= SEQ_CTL2;
            end
          end
          SEQ_DIV2: begin
            div_sh.scale[2*SEG_W-1 -: SEG_W] <= byte_i[SEG_W-1:0];
            seq <= SEQ_DIV3;
          end
          SEQ_DIV3: begin
            div_sh.scale[SEG_W-1:0] <= byte_i[SEG_W-1:0];
            div_ok <= 1'b1;
            seq    <= SEQ_SEL;
          end
          default: begin
            c2_sh <= '{dbl_off: byte_i[7], dbl_hi: byte_i[6], sw: byte_i[SW_N-1:0]};
            c2_ok <= 1'b1;
            seq   <= SEQ_SEL;
          end
        endcase
      end
    end
  end

  // R6
  hold_until_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_i |=> ($stable(div_q) && $stable(c1_q) && $stable(c2_q)));

  // R8
  update_single_chk: assert property (@(posedge clk) disable iff (rst)
    update_o |=> !update_o);

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);

  // R7
  valid_rise_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(stop_i));
endmodule

// File: rtl/synth_cfg_i2c.sv
module synth_cfg_i2c
  import synth_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b11000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         addr_sel_i,
  output logic               sda_oe_o,
  output logic [SCALE_W-1:0] scale_o,
  output logic [1:0]         ref_sel_o,
  output logic [1:0]         pump_cur_o,
  output logic               pump_off_o,
  output logic               test_o,
  output logic               tune_off_o,
  output logic               dbl_off_o,
  output logic               dbl_hi_o,
  output logic [SW_N-1:0]    sw_o,
  output logic               update_o,
  output logic               scale_valid_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_vld, rx_sel;
  div_cfg_t  div_q;
  ctl1_cfg_t c1_q;
  ctl2_cfg_t c2_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_wr_rx #(.ADDR_HI(ADDR_HI)) u_rx (
    .clk(clk), .rst(rst), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev), .addr_lo_i(addr_sel_i),
    .byte_o(rx_byte), .byte_vld_o(rx_vld), .sel_o(rx_sel), .ack_o(sda_oe_o)
  );

  cfg_decode u_dec (
    .clk(clk), .rst(rst), .byte_i(rx_byte), .byte_vld_i(rx_vld), .sel_i(rx_sel),
    .start_i(start_ev), .stop_i(stop_ev),
    .div_q(div_q), .c1_q(c1_q), .c2_q(c2_q),
    .update_o(update_o), .valid_o(scale_valid_o)
  );

  assign scale_o    = div_q.scale;
  assign ref_sel_o  = div_q.ref_sel;
  assign pump_cur_o = c1_q.pump_cur;
  assign pump_off_o = c1_q.pump_off;
  assign test_o     = c1_q.test_en;
  assign tune_off_o = c1_q.tune_off;
  assign dbl_off_o  = c2_q.dbl_off;
  assign dbl_hi_o   = c2_q.dbl_hi;
  assign sw_o       = c2_q.sw;
endmodule

// File: tb/tb_synth_cfg_i2c.sv
module tb_synth_cfg_i2c;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b10;
  logic sda_oe;
  logic sda_line;
  logic [14:0] scale;
  logic [1:0] ref_sel, pump_cur;
  logic pump_off, test_en, tune_off, dbl_off, dbl_hi, update, valid;
  logic [5:0] sw;

  int n_chk = 0, n_fail = 0, upd_cnt = 0;
  bit done = 0;

  logic [14:0] e_scale = '0;
  logic [1:0]  e_ref = '0, e_cur = '0;
  logic        e_poff = 0, e_test = 0, e_toff = 0, e_doff = 0, e_dhi = 0, e_valid = 0;
  logic [5:0]  e_sw = '0;
  int          e_upd = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  synth_cfg_i2c dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .addr_sel_i(addr_sel),
    .sda_oe_o(sda_oe), .scale_o(scale), .ref_sel_o(ref_sel), .pump_cur_o(pump_cur),
    .pump_off_o(pump_off), .test_o(test_en), .tune_off_o(tune_off),
    .dbl_off_o(dbl_off), .dbl_hi_o(dbl_hi), .sw_o(sw), .update_o(update),
    .scale_valid_o(valid)
  );

  always @(posedge clk) begin
    if (rst) upd_cnt <= 0;
    else if (update) upd_cnt <= upd_cnt + 1;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_b(input logic [1:0] as, input logic rd);
    return {5'b11000, as, rd};
  endfunction
  function automatic logic [7:0] d1_b(input logic [1:0] rs, input logic [14:0] sc);
    return {1'b0, rs, 2'b00, sc[14:12]};
  endfunction
  function automatic logic [7:0] d2_b(input logic [14:0] sc);
    return {2'b10, sc[11:6]};
  endfunction
  function automatic logic [7:0] d3_b(input logic [14:0] sc);
    return {2'b01, sc[5:0]};
  endfunction
  function automatic logic [7:0] c1_b(input logic to, input logic t, input logic po,
                                      input logic [1:0] cur);
    return {3'b110, to, t, po, cur};
  endfunction
  function automatic logic [7:0] c2_b(input logic doff, input logic dhi, input logic [5:0] s);
    return {doff, dhi, s};
  endfunction

  task automatic i2c_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1; wq(Q);
      if (sda_oe) begin n_chk++; n_fail++; $display("FAIL R2 actual=1 expected=0 (pull-down in data bit)"); end
      wq(Q); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    acked = ~sda_line;
    wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic check_outputs(input string req);
    check(req, scale, e_scale);
    check(req, ref_sel, e_ref);
    check(req, {tune_off, test_en, pump_off, pump_cur}, {e_toff, e_test, e_poff, e_cur});
    check(req, {dbl_off, dbl_hi, sw}, {e_doff, e_dhi, e_sw});
    check(req, valid, e_valid);
    check(req, upd_cnt, e_upd);
  endtask

  // R10: reset state
  task automatic t_reset();
    check_outputs("R10");
    check("R10 sda_oe", sda_oe, 0);
  endtask

  // R7, R9: incomplete divider group is not applied
  task automatic t_partial_div();
    logic a;
    i2c_start();
    send_byte(addr_b(addr_sel, 0), a); check("R1 addr ack", a, 1);
    send_byte(d1_b(2'b11, 15'h7FFF), a); check("R2 ack", a, 1);
    send_byte(d2_b(15'h7FFF), a);
    i2c_stop();
    e_upd++;
    check_outputs("R7 partial divider");
  endtask

  // R3, R4, R6, R8, R9: full transfer, held until STOP
  task automatic t_full();
    logic a;
    logic [14:0] sc = 15'h5A3C;
    i2c_start();
    send_byte(addr_b(addr_sel, 0), a);
    send_byte(d1_b(2'b10, sc), a);
    send_byte(d2_b(sc), a);
    send_byte(d3_b(sc), a); check("R2 ack d3", a, 1);
    send_byte(c1_b(1, 0, 1, 2'b01), a);
    send_byte(c2_b(0, 1, 6'b101100), a); check("R2 ack c2", a, 1);
    check_outputs("R6 before STOP");
    i2c_stop();
    e_scale = sc; e_ref = 2'b10; e_toff = 1; e_test = 0; e_poff = 1; e_cur = 2'b01;
    e_doff = 0; e_dhi = 1; e_sw = 6'b101100; e_valid = 1; e_upd++;
    check_outputs("R3 R4 R8 R9 full write");
  endtask

  // R1: wrong address and read request ignored
  task automatic t_foreign();
    logic a;
    i2c_start();
    send_byte(addr_b(~addr_sel, 0), a); check("R1 wrong addr nack", a, 0);
    send_byte(d1_b(2'b01, 15'h0123), a);
    send_byte(d2_b(15'h0123), a);
    send_byte(d3_b(15'h0123), a);
    i2c_stop();
    check_outputs("R1 wrong addr");
    i2c_start();
    send_byte(addr_b(addr_sel, 1), a); check("R1 read nack", a, 0);
    send_byte(c1_b(0, 1, 0, 2'b11), a);
    send_byte(c2_b(1, 1, 6'h3F), a);
    i2c_stop();
    check_outputs("R1 read request");
  endtask

  // R5, R7: ignored 10 selector byte, control-only transfer keeps scale
  task automatic t_ctrl_only();
    logic a;
    i2c_start();
    send_byte(addr_b(addr_sel, 0), a);
    send_byte(8'hA5, a); check("R5 ack of ignored byte", a, 1);
    send_byte(c1_b(0, 1, 0, 2'b10), a);
    send_byte(c2_b(1, 0, 6'b010011), a);
    i2c_stop();
    e_toff = 0; e_test = 1; e_poff = 0; e_cur = 2'b10;
    e_doff = 1; e_dhi = 0; e_sw = 6'b010011; e_upd++;
    check_outputs("R5 R7 control only");
  endtask

  // R1, R9: new strap bits, divider update
  task automatic t_new_addr();
    logic a;
    logic [14:0] sc = 15'h0800;
    addr_sel = 2'b01;
    wq(4);
    i2c_start();
    send_byte(addr_b(2'b01, 0), a); check("R1 strap 01 ack", a, 1);
    send_byte(d1_b(2'b01, sc), a);
    send_byte(d2_b(sc), a);
    send_byte(d3_b(sc), a);
    i2c_stop();
    e_scale = sc; e_ref = 2'b01; e_upd++;
    check_outputs("R1 R3 R9 new address");
  endtask

  initial begin
    wq(5);
    rst = 0;
    wq(3);
    t_reset();
    t_partial_div();
    t_full();
    t_foreign();
    t_ctrl_only();
    t_new_addr();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule